// File: doc/BRIEF.md
# Chip-Select Read Sequencer

This block runs one read access on an external asynchronous memory bus for a single chip-select region. A host asks for a read with a request and an address. The block then drives the address, an active-low chip select, an active-low output enable and an optional active-low byte enable. Once the access ends, it returns the captured data with a one-cycle ready pulse.

The access ends in one of two ways, chosen per access from a configuration input. In the first, a programmed internal wait count sets the length. In the second, an external active-low acknowledge input ends it. The acknowledge passes through a two-flop synchronizer. If no acknowledge arrives within a bounded window, the access is forced to end and a timeout flag is raised. After the end point, the strobes release in a fixed order. Output enable and byte enable negate first. Chip select releases one and a half cycles later, on a falling clock edge.

Configuration is sampled when a request is accepted. Requests are accepted only while the block is idle.

Top module: `cs_read_ctrl`

## Requirements
- R1: On the rising edge that accepts a request, `mem_addr_o` takes `addr_i`, and `mem_cs_no` goes low on the following falling edge.
- R2: With `cfg_oe_dly_i`=0, `mem_oe_no` goes low on the accept edge. With `cfg_oe_dly_i`=1, it goes low one cycle later.
- R3: With `cfg_be_off_i`=0, `mem_be_no` follows `mem_oe_no`. With `cfg_be_off_i`=1, it stays high for the whole access.
- R4: Acknowledge mode is selected only when `cfg_wait_i`=6'b111111 and `cfg_ack_sel_i`=1. In every other case, the end point is the edge N+1 cycles after output enable asserts, where N=`cfg_wait_i`, and `mem_ack_ni` has no effect.
- R5: In acknowledge mode, `mem_ack_ni` driven low after rising edge P ends the access at edge P+3, which includes two synchronizer stages.
- R6: `mem_data_i` is captured on the end-point edge and is presented on `rdata_o` while `ready_o` is high.
- R7: `mem_oe_no` and `mem_be_no` go high two rising edges after the end point.
- R8: `mem_cs_no` goes high on the falling edge 1.5 cycles after `mem_oe_no` goes high, and it is low for at least 3 cycles per access.
- R9: In acknowledge mode, if no acknowledge is seen by the ACK_LIMIT-th edge after output enable asserts, that edge becomes the end point and `timeout_o` is high with `ready_o`. An acknowledge seen on that same edge wins, and no timeout is raised.
- R10: `ready_o` is high for exactly one cycle, on the rising edge after chip select releases. `timeout_o` is never high without `ready_o`.
- R11: A request held high during an access starts nothing. The next access is accepted on the edge after `ready_o` falls.
- R12: During reset, all strobes are high and `ready_o` and `timeout_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request, sampled while idle |
| addr_i | input | AW | Read address |
| cfg_wait_i | input | WSW | Wait-state count; all ones selects acknowledge mode together with cfg_ack_sel_i |
| cfg_ack_sel_i | input | 1 | Acknowledge select |
| cfg_oe_dly_i | input | 1 | Delay output/byte enable by one cycle |
| cfg_be_off_i | input | 1 | Keep byte enable inactive on reads |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| timeout_o | output | 1 | Acknowledge timeout, valid with ready_o |
| mem_addr_o | output | AW | External address |
| mem_cs_no | output | 1 | Active-low chip select |
| mem_oe_no | output | 1 | Active-low output enable |
| mem_be_no | output | 1 | Active-low byte enable |
| mem_ack_ni | input | 1 | Active-low external acknowledge (asynchronous) |
| mem_data_i | input | DW | External read data |

## Verification
The bench builds the block with ACK_LIMIT=12 instead of the default 1020. This keeps the timeout path and its tie with a late acknowledge within a few dozen cycles. It also uses the default 24-bit address, 16-bit data, a 6-bit wait field and two synchronizer stages. With these values the bench can reach the largest internal count (63), both output-enable delays, a suppressed byte enable, the exact tie between an acknowledge and the limit, and back-to-back requests from a held request line.

// File: rtl/cs_rd_pkg.sv
package cs_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_HOLD0,
    ST_HOLD1,
    ST_NEG,
    ST_REL,
    ST_RDY
  } seq_state_e;
endpackage

// File: rtl/cs_rd_sync.sv
module cs_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/cs_rd_neg_stage.sv
module cs_rd_neg_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  output logic cs_no
);
  // Falling-edge stage gives the half-cycle offset on chip select
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_no <= 1'b1;
    else         cs_no <= ~active_i;
  end
endmodule

// File: rtl/cs_rd_seq.sv
module cs_rd_seq
  import cs_rd_pkg::*;
#(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int WSW       = 6,
  parameter int ACK_LIMIT = 1020
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [WSW-1:0] cfg_wait_i,
  input  logic           cfg_ack_sel_i,
  input  logic           cfg_oe_dly_i,
  input  logic           cfg_be_off_i,
  input  logic           ack_s_i,
  input  logic [DW-1:0]  mem_data_i,
  output seq_state_e     state_o,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  rdata_o,
  output logic           tmo_o,
  output logic           be_off_o
);
  localparam int LW = $clog2(ACK_LIMIT);
  localparam int CW = ((LW > WSW) ? LW : WSW) + 1;

  seq_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [WSW-1:0] n_q;
  logic           ack_mode_q;
  logic           done_w;
  logic           lim_w;

  assign lim_w  = (cnt_q == CW'(ACK_LIMIT - 1));
  assign done_w = ack_mode_q ? (!ack_s_i || lim_w)
                             : (cnt_q == {{(CW-WSW){1'b0}}, n_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      n_q        <= '0;
      ack_mode_q <= 1'b0;
      be_off_o   <= 1'b0;
      addr_o     <= '0;
      rdata_o    <= '0;
      tmo_o      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_o     <= addr_i;
          n_q        <= cfg_wait_i;
          ack_mode_q <= (&cfg_wait_i) && cfg_ack_sel_i;
          be_off_o   <= cfg_be_off_i;
          cnt_q      <= '0;
          tmo_o      <= 1'b0;
          state_q    <= cfg_oe_dly_i ? ST_SETUP : ST_WAIT;
        end
        ST_SETUP: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (done_w) begin
            rdata_o <= mem_data_i;
            tmo_o   <= ack_mode_q && ack_s_i;  // limit reached, no ack
            state_q <= ST_HOLD0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD0: state_q <= ST_HOLD1;
        ST_HOLD1: state_q <= ST_NEG;
        ST_NEG:   state_q <= ST_REL;
        ST_REL:   state_q <= ST_RDY;
        ST_RDY:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/cs_read_ctrl.sv
module cs_read_ctrl
  import cs_rd_pkg::*;
#(
  parameter int AW          = 24,
  parameter int DW          = 16,
  parameter int WSW         = 6,
  parameter int ACK_LIMIT   = 1020,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [WSW-1:0] cfg_wait_i,
  input  logic           cfg_ack_sel_i,
  input  logic           cfg_oe_dly_i,
  input  logic           cfg_be_off_i,
  output logic           ready_o,
  output logic [DW-1:0]  rdata_o,
  output logic           timeout_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic           mem_cs_no,
  output logic           mem_oe_no,
  output logic           mem_be_no,
  input  logic           mem_ack_ni,
  input  logic [DW-1:0]  mem_data_i
);
  seq_state_e state;
  logic       ack_s;
  logic       tmo;
  logic       be_off;
  logic       cs_active;
  logic       seq_idle;

  cs_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (mem_ack_ni),
    .q_o   (ack_s)
  );

  cs_rd_seq #(
    .AW(AW), .DW(DW), .WSW(WSW), .ACK_LIMIT(ACK_LIMIT)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .addr_i       (addr_i),
    .cfg_wait_i   (cfg_wait_i),
    .cfg_ack_sel_i(cfg_ack_sel_i),
    .cfg_oe_dly_i (cfg_oe_dly_i),
    .cfg_be_off_i (cfg_be_off_i),
    .ack_s_i      (ack_s),
    .mem_data_i   (mem_data_i),
    .state_o      (state),
    .addr_o       (mem_addr_o),
    .rdata_o      (rdata_o),
    .tmo_o        (tmo),
    .be_off_o     (be_off)
  );

  assign seq_idle  = (state == ST_IDLE);
  assign cs_active = (state == ST_SETUP) || (state == ST_WAIT) ||
                     (state == ST_HOLD0) || (state == ST_HOLD1) ||
                     (state == ST_NEG);
  assign mem_oe_no = !((state == ST_WAIT) || (state == ST_HOLD0) ||
                       (state == ST_HOLD1));
  assign mem_be_no = mem_oe_no || be_off;
  assign ready_o   = (state == ST_RDY);
  assign timeout_o = ready_o && tmo;

  cs_rd_neg_stage u_cs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(cs_active),
    .cs_no   (mem_cs_no)
  );
endmodule

// File: rtl/cs_read_ctrl_chk.sv
module cs_read_ctrl_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [AW-1:0] addr_i,
  input logic          idle_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_cs_no,
  input logic          mem_oe_no,
  input logic          mem_be_no,
  input logic          ready_o,
  input logic          timeout_o
);
  logic [3:0] cs_low_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cs_low_cnt <= '0;
    else if (mem_cs_no)         cs_low_cnt <= '0;
    else if (cs_low_cnt != '1)  cs_low_cnt <= cs_low_cnt + 1'b1;
  end

  a_r1_cs_addr_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && req_i) |=> (!mem_cs_no && mem_addr_o == $past(addr_i)));

  a_r3_be_within_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_be_no |-> !mem_oe_no);

  a_r8_cs_after_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> (!mem_cs_no ##1 $rose(mem_cs_no)));

  a_r8_cs_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_cs_no) |-> (cs_low_cnt >= 4'd3));

  a_r9_timeout_with_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> ready_o);

  a_r10_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  a_r10_ready_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mem_cs_no);

  a_r11_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle_i |=> $stable(mem_addr_o));
endmodule

bind cs_read_ctrl cs_read_ctrl_chk #(.AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .addr_i    (addr_i),
  .idle_i    (seq_idle),
  .mem_addr_o(mem_addr_o),
  .mem_cs_no (mem_cs_no),
  .mem_oe_no (mem_oe_no),
  .mem_be_no (mem_be_no),
  .ready_o   (ready_o),
  .timeout_o (timeout_o)
);

// File: tb/cs_read_ctrl_bench.sv
`timescale 1ns/100ps
module cs_read_ctrl_bench;
  localparam int AW  = 24;
  localparam int DW  = 16;
  localparam int LIM = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [5:0]    cfg_wait = '0;
  logic          cfg_sel = 1'b0, cfg_dly = 1'b0, cfg_beoff = 1'b0;
  logic          ready, timeout, cs_n, oe_n, be_n;
  logic          ack_n = 1'b1;
  logic [DW-1:0] rdata, mdata = '0;
  logic [AW-1:0] maddr;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cs_read_ctrl #(.AW(AW), .DW(DW), .WSW(6), .ACK_LIMIT(LIM), .SYNC_STAGES(2)) u_cs_read_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
    .cfg_wait_i(cfg_wait), .cfg_ack_sel_i(cfg_sel), .cfg_oe_dly_i(cfg_dly),
    .cfg_be_off_i(cfg_beoff), .ready_o(ready), .rdata_o(rdata), .timeout_o(timeout),
    .mem_addr_o(maddr), .mem_cs_no(cs_n), .mem_oe_no(oe_n), .mem_be_no(be_n),
    .mem_ack_ni(ack_n), .mem_data_i(mdata)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // a < 0: no acknowledge driven
  task automatic run_read(input string ctx, input logic [5:0] w, input logic sel, input logic dly,
                          input logic beoff, input int a, input int aw, input bit hold,
                          input logic [DW-1:0] d);
    bit ackmode;
    bit tmo;
    int ea;
    logic eoe, ebe;
    ackmode = (w == 6'h3F) && sel;
    tmo = 1'b0;
    if (ackmode) begin
      if (a >= 0 && a + 3 <= int'(dly) + LIM) ea = a + 3;
      else begin ea = int'(dly) + LIM; tmo = 1'b1; end
    end else begin
      ea = int'(dly) + int'(w) + 1;
    end
    req = 1'b1; addr = {8'h5A, d}; cfg_wait = w; cfg_sel = sel; cfg_dly = dly; cfg_beoff = beoff;
    mdata = ~d;
    for (int k = 0; k <= ea + 5; k++) begin
      @(posedge clk);
      #1;
      if (!hold) req = 1'b0;
      if (a >= 0 && k == a) ack_n = 1'b0;
      if (a >= 0 && k == a + aw) ack_n = 1'b1;
      if (k == ea - 1) mdata = d;
      if (k == ea) mdata = ~d;
      #3;
      if (k == 0) chk({"R1 ", ctx}, "addr", 32'(maddr), 32'({8'h5A, d}));
      chk({"R8 ", ctx}, "cs_n", 32'(cs_n), 32'(k > ea + 2));
      eoe = !(k >= int'(dly) && k <= ea + 1);
      chk({(k < ea) ? "R2 " : "R7 ", ctx}, "oe_n", 32'(oe_n), 32'(eoe));
      ebe = beoff ? 1'b1 : eoe;
      chk({"R3 ", ctx}, "be_n", 32'(be_n), 32'(ebe));
      chk({"R10 ", ctx}, "ready", 32'(ready), 32'(k == ea + 4));
      chk({"R9 ", ctx}, "timeout", 32'(timeout), 32'((k == ea + 4) && tmo));
      if (k == ea + 4) chk({"R6 ", ctx}, "rdata", 32'(rdata), 32'(d));
    end
    ack_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #4;
    chk("R12", "cs_n", 32'(cs_n), 32'd1);
    chk("R12", "oe_n", 32'(oe_n), 32'd1);
    chk("R12", "be_n", 32'(be_n), 32'd1);
    chk("R12", "ready", 32'(ready), 32'd0);
    chk("R12", "timeout", 32'(timeout), 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    run_read("R4 int n0",        6'd0,  1'b0, 1'b0, 1'b0, -1, 0, 1'b0, 16'h1234);
    run_read("R4 int n5 dly",    6'd5,  1'b0, 1'b1, 1'b1, -1, 0, 1'b0, 16'hBEEF);
    run_read("R4 int n63 ackign", 6'h3F, 1'b0, 1'b0, 1'b0, 2, 3, 1'b0, 16'h0F0F);
    run_read("R4 sel n62 ackign", 6'd62, 1'b1, 1'b1, 1'b0, 1, 2, 1'b0, 16'hA5A5);
    run_read("R5 ack a4",        6'h3F, 1'b1, 1'b0, 1'b0, 4, 1, 1'b0, 16'h4321);
    run_read("R5 ack a7 dly",    6'h3F, 1'b1, 1'b1, 1'b1, 7, 2, 1'b0, 16'hC3C3);
    run_read("R9 ack tie",       6'h3F, 1'b1, 1'b0, 1'b0, 9, 1, 1'b0, 16'h7777);
    run_read("R9 ack late",      6'h3F, 1'b1, 1'b0, 1'b0, 10, 1, 1'b0, 16'h1111);
    run_read("R9 no ack dly",    6'h3F, 1'b1, 1'b1, 1'b0, -1, 0, 1'b0, 16'h2222);
    run_read("R11 held a",       6'd2,  1'b0, 1'b0, 1'b0, -1, 0, 1'b1, 16'h3333);
    run_read("R11 held b",       6'd1,  1'b0, 1'b1, 1'b0, -1, 0, 1'b0, 16'h4444);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule